// File: doc/BRIEF.md
# Dual-Line TDM PCM Frame Capture

This block takes in two serial PCM backplane lines that run on one shared bit clock and one shared frame-sync strobe. Each 256-bit frame holds 32 eight-bit slots. The block turns every slot of both lines back into bytes and stores them in an on-chip buffer split into two halves. Within a half, each frame is stored channel by channel, with line A and line B side by side. A narrow mode carries only 24 channels on the same 256-bit frame. In that mode slots 24 to 31 are filler: they are not stored and are sent as zeros.

After a configured number of frames has filled one half, the block gives a one-cycle block-ready pulse, reports which half it just finished, and moves capture to the other half. A transmit side turns stored bytes back into bits on two output lines, in step with the receive frame. Each transmit word is read from the buffer just before the receiver overwrites it. As a result, a sample that arrives on a receive line leaves on the matching transmit line exactly two blocks later, in the same frame and slot position. A read port gives the stored words as 16-bit values.

An early frame sync is one that arrives before the frame has finished. It restarts the bit count and sets a framing-error flag that stays set until reset.

Top module: `pcm_dual_capture`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_a`, `tx_b`, `blk_rdy` and `frm_err` are low. Both transmit lines stay low until the first frame sync.
- R2: `fsync` sampled high in a cycle makes the next cycle bit time 0 of a frame. Slot s takes bit times 8s to 8s+7, most significant bit first, and a frame has 256 bit times. A sync in bit time 255 keeps frames back to back.
- R3: The sample of line L (A=0, B=1), slot s, frame f of half h is stored at word address h·N·64 + f·S + 2s + L. N is `FRAMES_PER_BLOCK`. S is 64 when `wide_frame` is 1 (32 slots) and 48 when it is 0 (24 slots).
- R4: `rd_data` shows the word at `rd_addr` one clock after the address is applied. It holds the 8-bit sample in bits 7:0, with bits 15:8 zero.
- R5: With `wide_frame` = 0, slots 24 to 31 are not stored, and both transmit lines are low during those slots.
- R6: `wide_frame` is sampled only at the first frame sync after reset and when capture switches halves. A change in the middle of a block has no effect until the next switch.
- R7: `blk_rdy` is high for exactly one cycle: the cycle after the last bit time of frame N−1 of a block. In that cycle `blk_half` gives the half just completed. Halves alternate, starting with half 0.
- R8: During slot s of frame f of a block, each transmit line sends the byte its receive line delivered at the same frame and slot two blocks earlier. A line stays low while the half being read has never been completed.
- R9: A frame sync while framing is active, in any bit time other than 255, restarts the count so that the next cycle is bit time 0, and sets `frm_err` until reset. This restart does not advance the frame index. The first sync from idle raises no error.
- R10: If no sync arrives at bit time 255, the count wraps to bit time 0 and capture continues without interruption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all lines are sampled and updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame-sync strobe, high during bit time 255 of the previous frame |
| wide_frame | input | 1 | 1 = 32 channels, 0 = 24 channels |
| rx_a | input | 1 | Serial receive line A |
| rx_b | input | 1 | Serial receive line B |
| rd_addr | input | $clog2(128·FRAMES_PER_BLOCK) | Buffer word address for the read port |
| rd_data | output | 16 | Buffer word, one cycle after `rd_addr` |
| tx_a | output | 1 | Serial transmit line A |
| tx_b | output | 1 | Serial transmit line B |
| blk_rdy | output | 1 | One-cycle pulse when a buffer half completes |
| blk_half | output | 1 | Half that has just completed, valid with `blk_rdy` |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions take for granted that `fsync` and both receive lines are synchronous to `clk`. They also assume `fsync` is a single-cycle strobe. The sticky-error and sync-alignment properties would still hold for wider strobes, but the block would resynchronize on every high cycle. The bench changes every input only at the falling edge and raises `fsync` for one cycle: in bit time 255, or at a chosen earlier bit time for the resync case. It changes `wide_frame` only while capture is idle or in the middle of a block, so the latching rule can be seen.

// File: rtl/pcm_cap_pkg.sv
package pcm_cap_pkg;

    localparam int SLOT_W       = 8;
    localparam int MAX_SLOTS    = 32;
    localparam int NARROW_SLOTS = 24;
    localparam int LINES        = 2;
    localparam int WORD_W       = 16;
    localparam int FRAME_BITS   = SLOT_W * MAX_SLOTS;
    localparam int CNT_W        = $clog2(FRAME_BITS);
    localparam int SLOT_IDX_W   = $clog2(MAX_SLOTS);
    localparam int BIT_IDX_W    = $clog2(SLOT_W);
    localparam int WIDE_STRIDE   = MAX_SLOTS * LINES;
    localparam int NARROW_STRIDE = NARROW_SLOTS * LINES;

    typedef logic [SLOT_W-1:0] sample_t;

    // Position of the current bit time inside the frame.
    typedef struct packed {
        logic                  active;
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bitpos;
        logic                  frame_end;
        logic                  start;
    } tdm_pos_t;

    function automatic logic [SLOT_IDX_W:0] slot_limit(input logic wide);
        return wide ? (SLOT_IDX_W+1)'(MAX_SLOTS) : (SLOT_IDX_W+1)'(NARROW_SLOTS);
    endfunction

    function automatic logic [7:0] frame_stride(input logic wide);
        return wide ? 8'(WIDE_STRIDE) : 8'(NARROW_STRIDE);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import pcm_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fsync,
    output tdm_pos_t pos,
    output logic     frm_err
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end else if (fsync) begin
            if (active_q && (cnt_q != LAST_BIT))
                err_q <= 1'b1;
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        pos.active    = active_q;
        pos.slot      = cnt_q[CNT_W-1:BIT_IDX_W];
        pos.bitpos    = cnt_q[BIT_IDX_W-1:0];
        pos.frame_end = active_q && (cnt_q == LAST_BIT);
        pos.start     = fsync && !active_q;
    end

    assign frm_err = err_q;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> ($past(fsync) && $past(active_q)));

    // R2
    sync_align_chk: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (active_q && cnt_q == '0));

endmodule

// File: rtl/slot_deser.sv
module slot_deser
    import pcm_cap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    din,
    output sample_t sample
);

    logic [SLOT_W-2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (active)
            sh_q <= {sh_q[SLOT_W-3:0], din};
    end

    // The byte is complete in the last bit time of a slot.
    assign sample = {sh_q, din};

endmodule

// File: rtl/pingpong_store.sv
module pingpong_store
    import pcm_cap_pkg::*;
#(
    parameter  int FRAMES = 16,
    localparam int HALF_WORDS = FRAMES * MAX_SLOTS * LINES,
    localparam int DEPTH      = 2 * HALF_WORDS,
    localparam int ADDR_W     = $clog2(DEPTH)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  tdm_pos_t             pos,
    input  logic                 wide_frame,
    input  sample_t [LINES-1:0]  rx_bytes,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic [LINES-1:0]     tx_bits,
    output logic                 blk_rdy,
    output logic                 blk_half
);

    localparam int OFF_W = $clog2(HALF_WORDS);
    localparam int FR_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1;

    sample_t mem [DEPTH];

    logic              half_q;
    logic [FR_W-1:0]   frame_q;
    logic [OFF_W-1:0]  fbase_q;
    logic              wide_q;
    logic [1:0]        filled_q;
    logic              blk_rdy_q;
    logic              blk_half_q;
    logic [WORD_W-1:0] rd_q;

    logic              in_range;
    logic              last_bit_of_slot;
    logic              wr_en;
    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] word_addr [LINES];

    assign in_range         = {1'b0, pos.slot} < slot_limit(wide_q);
    assign last_bit_of_slot = pos.active && (pos.bitpos == BIT_IDX_W'(SLOT_W - 1));
    assign wr_en            = last_bit_of_slot && in_range;
    assign line_base        = (half_q ? ADDR_W'(HALF_WORDS) : '0)
                            + ADDR_W'(fbase_q)
                            + ADDR_W'(pos.slot) * ADDR_W'(LINES);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        sample_t old_byte;
        assign word_addr[g] = line_base + ADDR_W'(g);
        // Read the word before this slot's write replaces it.
        assign old_byte   = mem[word_addr[g]];
        assign tx_bits[g] = pos.active && in_range && filled_q[half_q]
                          && old_byte[BIT_IDX_W'(SLOT_W - 1) - pos.bitpos];
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LINES; l++) begin
            if (wr_en)
                mem[word_addr[l]] <= rx_bytes[l];
        end
        rd_q <= {{(WORD_W-SLOT_W){1'b0}}, mem[rd_addr]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q     <= 1'b0;
            frame_q    <= '0;
            fbase_q    <= '0;
            wide_q     <= 1'b1;
            filled_q   <= 2'b00;
            blk_rdy_q  <= 1'b0;
            blk_half_q <= 1'b0;
        end else begin
            blk_rdy_q <= 1'b0;
            if (pos.start)
                wide_q <= wide_frame;
            if (pos.frame_end) begin
                if (frame_q == FR_W'(FRAMES - 1)) begin
                    frame_q          <= '0;
                    fbase_q          <= '0;
                    half_q           <= ~half_q;
                    filled_q[half_q] <= 1'b1;
                    blk_rdy_q        <= 1'b1;
                    blk_half_q       <= half_q;
                    wide_q           <= wide_frame;
                end else begin
                    frame_q <= frame_q + 1'b1;
                    fbase_q <= fbase_q + OFF_W'(frame_stride(wide_q));
                end
            end
        end
    end

    assign rd_data  = rd_q;
    assign blk_rdy  = blk_rdy_q;
    assign blk_half = blk_half_q;

    // R7
    blk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_rdy_q |=> !blk_rdy_q);

    // R7
    blk_half_chk: assert property (@(posedge clk) disable iff (rst)
        blk_rdy_q |-> (blk_half_q != half_q));

    // R5
    dummy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.active && !wide_q && pos.slot >= SLOT_IDX_W'(NARROW_SLOTS))
            |-> (tx_bits == '0 && !wr_en));

    // R6
    wide_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wide_q) |-> (blk_rdy_q || $past(pos.start)));

endmodule

// File: rtl/pcm_dual_capture.sv
module pcm_dual_capture
    import pcm_cap_pkg::*;
#(
    parameter  int FRAMES_PER_BLOCK = 16,
    localparam int BUF_ADDR_W = $clog2(2 * FRAMES_PER_BLOCK * MAX_SLOTS * LINES)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fsync,
    input  logic                  wide_frame,
    input  logic                  rx_a,
    input  logic                  rx_b,
    input  logic [BUF_ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  tx_a,
    output logic                  tx_b,
    output logic                  blk_rdy,
    output logic                  blk_half,
    output logic                  frm_err
);

    tdm_pos_t            pos;
    logic [LINES-1:0]    rx_bus;
    logic [LINES-1:0]    tx_bus;
    sample_t [LINES-1:0] rx_bytes;

    assign rx_bus = {rx_b, rx_a};

    tdm_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .fsync   (fsync),
        .pos     (pos),
        .frm_err (frm_err)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_rx
        slot_deser u_deser (
            .clk    (clk),
            .rst    (rst),
            .active (pos.active),
            .din    (rx_bus[g]),
            .sample (rx_bytes[g])
        );
    end

    pingpong_store #(.FRAMES(FRAMES_PER_BLOCK)) u_store (
        .clk        (clk),
        .rst        (rst),
        .pos        (pos),
        .wide_frame (wide_frame),
        .rx_bytes   (rx_bytes),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tx_bits    (tx_bus),
        .blk_rdy    (blk_rdy),
        .blk_half   (blk_half)
    );

    assign tx_a = tx_bus[0];
    assign tx_b = tx_bus[1];

endmodule

// File: tb/tb_pcm_dual_capture.sv
module tb_pcm_dual_capture;

    localparam int CLK_PERIOD = 10;
    localparam int FR   = 4;
    localparam int HALF = FR * 64;
    localparam int AW   = $clog2(2 * FR * 64);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fsync = 1'b0;
    logic          wide_frame = 1'b1;
    logic          rx_a = 1'b0;
    logic          rx_b = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          tx_a, tx_b, blk_rdy, blk_half, frm_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_dual_capture #(.FRAMES_PER_BLOCK(FR)) dut (
        .clk(clk), .rst(rst), .fsync(fsync), .wide_frame(wide_frame),
        .rx_a(rx_a), .rx_b(rx_b), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_a(tx_a), .tx_b(tx_b), .blk_rdy(blk_rdy), .blk_half(blk_half),
        .frm_err(frm_err)
    );

    function automatic logic [7:0] pat(input int k, input int f, input int s, input int l);
        return 8'(k * 53 + f * 29 + s * 7 + l * 101 + 5);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fsync = 1'b0; rx_a = 1'b0; rx_b = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sync_start();
        @(negedge clk);
        fsync = 1'b1;
    endtask

    // One frame: drives bit i in the cycle where the design is at bit time i (R2)
    task automatic run_frame(input int k, input int f, input int lim, input int first,
                             input bit do_sync, input bit exp_rdy, input int exp_half,
                             input string dummy_tag);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] da, db, ea, eb;
            int s, b;
            string tag;
            @(negedge clk);
            s = i / 8;
            b = 7 - (i % 8);
            da = pat(k, f, s, 0);
            db = pat(k, f, s, 1);
            rx_a = da[b];
            rx_b = db[b];
            fsync = (i == 255) && do_sync;
            if (k >= first + 2 && s < lim) begin
                ea = pat(k - 2, f, s, 0);
                eb = pat(k - 2, f, s, 1);
            end else begin
                ea = 8'h00;
                eb = 8'h00;
            end
            tag = (s >= lim) ? dummy_tag : "R8";
            check({tag, " tx_a"}, int'(tx_a), int'(ea[b]));
            check({tag, " tx_b"}, int'(tx_b), int'(eb[b]));
            if (i == 0) begin
                check("R7 blk_rdy at frame start", int'(blk_rdy), int'(exp_rdy));
                if (exp_rdy) check("R7 blk_half", int'(blk_half), exp_half);
            end
            if (i == 1) check("R7 blk_rdy one cycle", int'(blk_rdy), 0);
        end
    endtask

    task automatic run_block(input int k, input int lim, input int first,
                             input int skip_sync, input int flip_at, input string dummy_tag);
        for (int f = 0; f < FR; f++) begin
            if (f == flip_at) wide_frame = 1'b1;
            run_frame(k, f, lim, first, f != skip_sync, (f == 0) && (k > first),
                      (k - 1 - first) % 2, dummy_tag);
        end
    endtask

    task automatic tail_check(input int exp_half);
        @(negedge clk);
        fsync = 1'b0;
        check("R7 blk_rdy after last frame", int'(blk_rdy), 1);
        check("R7 blk_half after last frame", int'(blk_half), exp_half);
    endtask

    task automatic read_word(input string tag, input int addr, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = AW'(addr);
        @(negedge clk);
        check(tag, int'(rd_data), int'({8'h00, exp}));
    endtask

    // R1, R2, R7, R8, R10
    task automatic test_stream();
        do_reset();
        wide_frame = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 tx_a idle", int'(tx_a), 0);
            check("R1 tx_b idle", int'(tx_b), 0);
            check("R1 blk_rdy idle", int'(blk_rdy), 0);
            check("R1 frm_err idle", int'(frm_err), 0);
        end
        sync_start();
        run_block(0, 32, 0, -1, -1, "R5");
        run_block(1, 32, 0, 2, -1, "R5");   // R10: no sync after frame 2
        run_block(2, 32, 0, -1, -1, "R5");
        run_block(3, 32, 0, -1, -1, "R5");
        tail_check(1);
        check("R10 R9 no error from free run", int'(frm_err), 0);
    endtask

    // R3, R4: block 3 sits in half 1; reset leaves the buffer contents intact
    task automatic test_layout();
        do_reset();
        for (int f = 0; f < FR; f++)
            for (int s = 0; s < 32; s++)
                for (int l = 0; l < 2; l++)
                    read_word("R3 R4 wide layout", HALF + f * 64 + 2 * s + l, pat(3, f, s, l));
    endtask

    // R5, R6, R3 with 24 channels
    task automatic test_narrow();
        do_reset();
        wide_frame = 1'b0;
        sync_start();
        run_block(10, 24, 10, -1, -1, "R5");
        run_block(11, 24, 10, -1, -1, "R5");
        run_block(12, 24, 10, -1, 1, "R6");  // wide_frame rises mid block
        tail_check(0);
        do_reset();
        for (int f = 0; f < FR; f++)
            for (int s = 0; s < 24; s++)
                for (int l = 0; l < 2; l++)
                    read_word("R3 R5 R6 narrow layout", f * 48 + 2 * s + l, pat(12, f, s, l));
        wide_frame = 1'b1;
    endtask

    // R9
    task automatic test_resync();
        do_reset();
        wide_frame = 1'b1;
        sync_start();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rx_a = 1'b1;
            rx_b = 1'b0;
            fsync = (i == 99);
            if (i == 50) check("R9 first sync no error", int'(frm_err), 0);
        end
        run_block(20, 32, 20, -1, -1, "R5");
        tail_check(0);
        check("R9 frm_err sticky", int'(frm_err), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        test_stream();
        test_layout();
        test_narrow();
        test_resync();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule